// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block sits between descriptor memory and an Ethernet MAC transmitter. Software builds a ring of two-word transmit descriptors, writes the ring base, enables the block and pulses start. The sequencer then walks the ring. For each descriptor it reads the control word and then the buffer address. It hands the transmitter one buffer command at a time over a valid/ready handshake. When a frame finishes, it writes status into the control word of the frame's first descriptor.

The transmitter reports the outcome of each frame once, after it has accepted the last buffer command. The outcome is success, collision, retry limit or underrun. A collision replays the whole frame from its first descriptor. Errors stop the engine and send the ring pointer back to the base. A descriptor still owned by software at a frame boundary pauses the engine without error, and the next start resumes at that same descriptor. A halt request takes effect only at a frame boundary.

Top module: `txdesc_ring_engine`

## Requirements
- R1: For the descriptor at index i of a ring at base B, the control word is read at B+8i+4 before the address word at B+8i. The issued command carries the address word, control bits 10:0 as length, bit 15 as last-buffer and bit 16 as no-CRC.
- R2: A zero-length buffer is issued as an ordinary command, with no error.
- R3: A control word whose bit 31 (owned) is set, read at the start of a frame, clears tx_go. No command is issued, nothing is written, and the pointer stays put, so the next start resumes at that descriptor.
- R4: When a frame ends, only the first descriptor's control word is written. The written value has bit 31 set, bits 29:27 holding status, and all other bits as read. Later descriptors of the frame are never written.
- R5: After a descriptor whose control bit 30 (wrap) is set, the next descriptor fetched is at the ring base.
- R6: After DESC_MAX (1024) consecutive descriptors without a wrap bit, the pointer returns to the ring base.
- R7: An owned descriptor found after the first buffer of a frame produces a one-cycle bc_fcs_bad pulse. It also writes back status bits 28 and 27, clears tx_go and returns the pointer to the base.
- R8: A completion code of 1 (collision) re-fetches and re-issues the frame from its first descriptor, with no write-back for the aborted attempt.
- R9: Completion code 2 (retry limit) writes back bit 29, and code 3 (underrun) writes back bit 28. Either one clears tx_go and returns the pointer to the base. Code 0 (success) writes back status 0 and continues.
- R10: Out of reset tx_go is 0 and no command or memory request is active. A start pulse sets tx_go only while enabled, and a start pulse while running changes nothing. Dropping enable or writing a new base clears tx_go and returns the pointer to the base.
- R11: A halt pulse lets the current frame finish and write back, then clears tx_go before the next frame is fetched.
- R12: A frame that reaches MAX_BUFS (128) buffers without a last-buffer flag is handled like R7. A frame of exactly MAX_BUFS buffers ending in a last flag completes normally.
- R13: While bc_valid is high and bc_ready is low, the command stays valid and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Engine enable; low aborts and rewinds |
| tx_start | input | 1 | Start pulse |
| tx_halt | input | 1 | Halt request pulse |
| qbase_wr | input | 1 | Load a new ring base |
| qbase_addr | input | 32 | New ring base byte address |
| dm_req | output | 1 | Descriptor memory request |
| dm_we | output | 1 | Request is a write |
| dm_addr | output | 32 | Descriptor word byte address |
| dm_wdata | output | 32 | Write data |
| dm_ack | input | 1 | Request completed |
| dm_rdata | input | 32 | Read data, valid with dm_ack |
| bc_valid | output | 1 | Buffer command valid |
| bc_ready | input | 1 | Transmitter accepts command |
| bc_addr | output | 32 | Buffer byte address |
| bc_len | output | 11 | Buffer length in bytes |
| bc_last | output | 1 | Last buffer of frame |
| bc_nocrc | output | 1 | Suppress CRC for this frame |
| bc_fcs_bad | output | 1 | Pulse: corrupt the current frame's check sequence |
| fc_valid | input | 1 | Frame completion strobe |
| fc_code | input | 2 | 0 ok, 1 collision, 2 retry limit, 3 underrun |
| tx_go | output | 1 | Engine running flag |

## Verification
The hardest situations to reach are the ones that depend on ring length and frame length. One is the silent rollover after 1024 descriptors with no wrap bit. Another is a frame that hits the 128-buffer limit. The bench builds these directly as memory images: 1024 one-buffer frames of length zero, and a 128-buffer frame with and without a final last flag. After each run it refreshes descriptor 0 and restarts, which proves from the command stream alone that the pointer sits at the base. Collision replay is exercised by queueing completion codes, so the same frame is accepted twice with only one write-back.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LEN_W    = 11;
  localparam int unsigned B_OWNED  = 31;
  localparam int unsigned B_WRAP   = 30;
  localparam int unsigned B_NOCRC  = 16;
  localparam int unsigned B_LAST   = 15;

  typedef enum logic [1:0] {
    TXC_OK    = 2'd0,
    TXC_COLL  = 2'd1,
    TXC_RETRY = 2'd2,
    TXC_UNDER = 2'd3
  } txc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CTL,
    ST_RD_ADR,
    ST_ISSUE,
    ST_WAIT,
    ST_WBACK
  } seq_e;

  typedef struct packed {
    logic retry;
    logic underrun;
    logic exhaust;
  } txst_t;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int unsigned DESC_MAX = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_ld,
  input  logic [31:0] base_in,
  input  logic        to_base,
  input  logic        adv,
  input  logic        adv_wrap,
  input  logic        mark,
  input  logic        back,
  output logic [31:0] cur_addr,
  output logic [31:0] first_addr
);
  localparam int unsigned IDX_W = (DESC_MAX > 1) ? $clog2(DESC_MAX) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_MAX - 1);

  logic [31:0]      base_q, base_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] first_q, first_d;
  logic             roll;

  assign roll = adv_wrap || (idx_q == IDX_LAST);

  always_comb begin
    base_d  = base_q;
    idx_d   = idx_q;
    first_d = first_q;
    if (base_ld) begin
      base_d  = base_in;
      idx_d   = '0;
      first_d = '0;
    end else if (to_base) begin
      idx_d   = '0;
      first_d = '0;
    end else begin
      if (back) begin
        idx_d = first_q;
      end else if (adv) begin
        idx_d = roll ? '0 : idx_q + 1'b1;
      end
      if (mark) begin
        first_d = idx_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      idx_q   <= '0;
      first_q <= '0;
    end else begin
      base_q  <= base_d;
      idx_q   <= idx_d;
      first_q <= first_d;
    end
  end

  assign cur_addr   = base_q + {{(29-IDX_W){1'b0}}, idx_q, 3'b000};
  assign first_addr = base_q + {{(29-IDX_W){1'b0}}, first_q, 3'b000};

  AST_ROLL_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !back && !base_ld && !to_base && idx_q == IDX_LAST) |=> (cur_addr == base_q)); // R6
  AST_REPLAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (back && !base_ld && !to_base) |=> (cur_addr == $past(first_addr))); // R8
endmodule

// File: rtl/txr_go_ctrl.sv
module txr_go_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_p,
  input  logic halt_p,
  input  logic base_wr,
  input  logic stop_keep,
  input  logic stop_err,
  input  logic seq_idle,
  output logic go,
  output logic halt_pend
);
  logic go_q, go_d;
  logic halt_q, halt_d;
  logic halt_take;
  logic kill;

  assign halt_take = halt_q && go_q && seq_idle;
  assign kill      = !en || base_wr || stop_keep || stop_err || halt_take;

  always_comb begin
    go_d = go_q;
    if (kill) begin
      go_d = 1'b0;
    end else if (start_p) begin
      go_d = 1'b1;
    end
    halt_d = (halt_q || halt_p) && go_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      go_q   <= go_d;
      halt_q <= halt_d;
    end
  end

  assign go        = go_q;
  assign halt_pend = halt_q;

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !go); // R10
  AST_HALT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (go && en && !base_wr && !stop_keep && !stop_err && !seq_idle) |=> go); // R11
endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
#(
  parameter int unsigned MAX_BUFS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        abort,
  input  logic        go,
  input  logic        halt_pend,
  input  logic [31:0] cur_addr,
  input  logic [31:0] first_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [31:0] cmd_addr,
  output logic [10:0] cmd_len,
  output logic        cmd_last,
  output logic        cmd_nocrc,
  output logic        fcs_bad,
  input  logic        done_valid,
  input  logic [1:0]  done_code,
  output logic        ptr_adv,
  output logic        ptr_wrap,
  output logic        ptr_mark,
  output logic        ptr_back,
  output logic        stop_keep,
  output logic        stop_err,
  output logic        seq_idle
);
  localparam int unsigned BC_W = $clog2(MAX_BUFS + 1);
  localparam logic [BC_W-1:0] BC_LIMIT = BC_W'(MAX_BUFS);
  localparam txst_t ST_NONE  = '{retry: 1'b0, underrun: 1'b0, exhaust: 1'b0};
  localparam txst_t ST_MID   = '{retry: 1'b0, underrun: 1'b1, exhaust: 1'b1};
  localparam txst_t ST_RETRY = '{retry: 1'b1, underrun: 1'b0, exhaust: 1'b0};
  localparam txst_t ST_UNDER = '{retry: 1'b0, underrun: 1'b1, exhaust: 1'b0};

  seq_e             state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             last_q, last_d;
  logic             nocrc_q, nocrc_d;
  logic             wrap_q, wrap_d;
  logic [31:0]      baddr_q, baddr_d;
  logic [27:0]      fctl_q, fctl_d;
  logic [BC_W-1:0]  bcnt_q, bcnt_d, bcnt_inc;
  txst_t            st_q, st_d;
  logic             err_q, err_d;
  logic             fcs_q, fcs_d;
  logic             unused_bits;

  assign bcnt_inc    = bcnt_q + 1'b1;
  assign unused_bits = ^{mem_rdata[29:27]};

  always_comb begin
    state_d   = state_q;
    len_d     = len_q;
    last_d    = last_q;
    nocrc_d   = nocrc_q;
    wrap_d    = wrap_q;
    baddr_d   = baddr_q;
    fctl_d    = fctl_q;
    bcnt_d    = bcnt_q;
    st_d      = st_q;
    err_d     = err_q;
    fcs_d     = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_addr + 32'd4;
    mem_wdata = {1'b1, fctl_q[27], st_q, fctl_q[26:0]};
    cmd_valid = 1'b0;
    ptr_adv   = 1'b0;
    ptr_wrap  = 1'b0;
    ptr_mark  = 1'b0;
    ptr_back  = 1'b0;
    stop_keep = 1'b0;
    stop_err  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go && !halt_pend) begin
          state_d = ST_RD_CTL;
        end
      end
      ST_RD_CTL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (mem_rdata[B_OWNED]) begin
            if (bcnt_q == '0) begin
              stop_keep = 1'b1;
              state_d   = ST_IDLE;
            end else begin
              st_d    = ST_MID;
              err_d   = 1'b1;
              fcs_d   = 1'b1;
              state_d = ST_WBACK;
            end
          end else begin
            len_d   = mem_rdata[LEN_W-1:0];
            last_d  = mem_rdata[B_LAST];
            nocrc_d = mem_rdata[B_NOCRC];
            wrap_d  = mem_rdata[B_WRAP];
            if (bcnt_q == '0) begin
              fctl_d   = {mem_rdata[B_WRAP], mem_rdata[26:0]};
              ptr_mark = 1'b1;
            end
            state_d = ST_RD_ADR;
          end
        end
      end
      ST_RD_ADR: begin
        mem_req  = 1'b1;
        mem_addr = cur_addr;
        if (mem_ack) begin
          baddr_d = mem_rdata;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        cmd_valid = 1'b1;
        if (cmd_ready) begin
          ptr_adv  = 1'b1;
          ptr_wrap = wrap_q;
          bcnt_d   = bcnt_inc;
          if (last_q) begin
            state_d = ST_WAIT;
          end else if (bcnt_inc == BC_LIMIT) begin
            st_d    = ST_MID;
            err_d   = 1'b1;
            fcs_d   = 1'b1;
            state_d = ST_WBACK;
          end else begin
            state_d = ST_RD_CTL;
          end
        end
      end
      ST_WAIT: begin
        if (done_valid) begin
          unique case (done_code)
            TXC_OK: begin
              st_d    = ST_NONE;
              err_d   = 1'b0;
              state_d = ST_WBACK;
            end
            TXC_COLL: begin
              ptr_back = 1'b1;
              bcnt_d   = '0;
              state_d  = ST_RD_CTL;
            end
            TXC_RETRY: begin
              st_d    = ST_RETRY;
              err_d   = 1'b1;
              state_d = ST_WBACK;
            end
            default: begin
              st_d    = ST_UNDER;
              err_d   = 1'b1;
              state_d = ST_WBACK;
            end
          endcase
        end
      end
      ST_WBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = first_addr + 32'd4;
        if (mem_ack) begin
          bcnt_d   = '0;
          stop_err = err_q;
          err_d    = 1'b0;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort) begin
      state_d = ST_IDLE;
      bcnt_d  = '0;
      err_d   = 1'b0;
      fcs_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      last_q  <= 1'b0;
      nocrc_q <= 1'b0;
      wrap_q  <= 1'b0;
      baddr_q <= '0;
      fctl_q  <= '0;
      bcnt_q  <= '0;
      st_q    <= ST_NONE;
      err_q   <= 1'b0;
      fcs_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      last_q  <= last_d;
      nocrc_q <= nocrc_d;
      wrap_q  <= wrap_d;
      baddr_q <= baddr_d;
      fctl_q  <= fctl_d;
      bcnt_q  <= bcnt_d;
      st_q    <= st_d;
      err_q   <= err_d;
      fcs_q   <= fcs_d;
    end
  end

  assign cmd_addr  = baddr_q;
  assign cmd_len   = len_q;
  assign cmd_last  = last_q;
  assign cmd_nocrc = nocrc_q;
  assign fcs_bad   = fcs_q;
  assign seq_idle  = (state_q == ST_IDLE);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !abort) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_len) && $stable(cmd_last) && $stable(cmd_nocrc))); // R13
  AST_FCS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_bad |=> !fcs_bad); // R7
  AST_WB_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[B_OWNED]); // R4
  AST_BUF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= BC_LIMIT); // R12
  AST_CTL_BEFORE_ADR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ADR) |-> ($past(state_q) == ST_RD_CTL || $past(state_q) == ST_RD_ADR)); // R1
endmodule

// File: rtl/txdesc_ring_engine.sv
module txdesc_ring_engine #(
  parameter int unsigned DESC_MAX = 1024,
  parameter int unsigned MAX_BUFS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_enable,
  input  logic        tx_start,
  input  logic        tx_halt,
  input  logic        qbase_wr,
  input  logic [31:0] qbase_addr,
  output logic        dm_req,
  output logic        dm_we,
  output logic [31:0] dm_addr,
  output logic [31:0] dm_wdata,
  input  logic        dm_ack,
  input  logic [31:0] dm_rdata,
  output logic        bc_valid,
  input  logic        bc_ready,
  output logic [31:0] bc_addr,
  output logic [10:0] bc_len,
  output logic        bc_last,
  output logic        bc_nocrc,
  output logic        bc_fcs_bad,
  input  logic        fc_valid,
  input  logic [1:0]  fc_code,
  output logic        tx_go
);
  logic [31:0] cur_addr, first_addr;
  logic        ptr_adv, ptr_wrap, ptr_mark, ptr_back;
  logic        stop_keep, stop_err, seq_idle;
  logic        halt_pend;
  logic        abort;

  assign abort = !tx_enable || qbase_wr;

  txr_ring_ptr #(.DESC_MAX(DESC_MAX)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_ld    (qbase_wr),
    .base_in    (qbase_addr),
    .to_base    (!tx_enable || stop_err),
    .adv        (ptr_adv),
    .adv_wrap   (ptr_wrap),
    .mark       (ptr_mark),
    .back       (ptr_back),
    .cur_addr   (cur_addr),
    .first_addr (first_addr)
  );

  txr_go_ctrl u_go (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (tx_enable),
    .start_p   (tx_start),
    .halt_p    (tx_halt),
    .base_wr   (qbase_wr),
    .stop_keep (stop_keep),
    .stop_err  (stop_err),
    .seq_idle  (seq_idle),
    .go        (tx_go),
    .halt_pend (halt_pend)
  );

  txr_seq #(.MAX_BUFS(MAX_BUFS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (abort),
    .go         (tx_go),
    .halt_pend  (halt_pend),
    .cur_addr   (cur_addr),
    .first_addr (first_addr),
    .mem_req    (dm_req),
    .mem_we     (dm_we),
    .mem_addr   (dm_addr),
    .mem_wdata  (dm_wdata),
    .mem_ack    (dm_ack),
    .mem_rdata  (dm_rdata),
    .cmd_valid  (bc_valid),
    .cmd_ready  (bc_ready),
    .cmd_addr   (bc_addr),
    .cmd_len    (bc_len),
    .cmd_last   (bc_last),
    .cmd_nocrc  (bc_nocrc),
    .fcs_bad    (bc_fcs_bad),
    .done_valid (fc_valid),
    .done_code  (fc_code),
    .ptr_adv    (ptr_adv),
    .ptr_wrap   (ptr_wrap),
    .ptr_mark   (ptr_mark),
    .ptr_back   (ptr_back),
    .stop_keep  (stop_keep),
    .stop_err   (stop_err),
    .seq_idle   (seq_idle)
  );

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_go |-> (!bc_valid && !dm_req)); // R10
  AST_STOP_KEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_keep |-> !dm_we); // R3
endmodule

// File: tb/test_txdesc_ring_engine.sv
module test_txdesc_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_enable, tx_start, tx_halt, qbase_wr;
  logic [31:0] qbase_addr;
  logic        dm_req, dm_we, dm_ack;
  logic [31:0] dm_addr, dm_wdata, dm_rdata;
  logic        bc_valid, bc_ready, bc_last, bc_nocrc, bc_fcs_bad;
  logic [31:0] bc_addr;
  logic [10:0] bc_len;
  logic        fc_valid;
  logic [1:0]  fc_code;
  logic        tx_go;

  always #4 clk = ~clk;

  txdesc_ring_engine i_txdesc_ring_engine (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_start(tx_start),
    .tx_halt(tx_halt), .qbase_wr(qbase_wr), .qbase_addr(qbase_addr),
    .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .dm_ack(dm_ack), .dm_rdata(dm_rdata), .bc_valid(bc_valid), .bc_ready(bc_ready),
    .bc_addr(bc_addr), .bc_len(bc_len), .bc_last(bc_last), .bc_nocrc(bc_nocrc),
    .bc_fcs_bad(bc_fcs_bad), .fc_valid(fc_valid), .fc_code(fc_code), .tx_go(tx_go)
  );

  typedef struct {
    logic [31:0] a;
    logic [10:0] l;
    logic        last;
    logic        nocrc;
  } cmd_t;

  logic [31:0] mem [int unsigned];
  cmd_t        exp_cmd [$];
  logic [63:0] exp_wb [$];
  int          codes [$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          fcs_cnt = 0;
  int          bp_cnt = 0;
  int          done_tmr = 0;
  int          cyc = 0;
  string       cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ctl(input int len, input bit last, input bit nocrc,
                                      input bit owned, input bit wrap);
    return {owned, wrap, 3'b000, 10'd0, nocrc, last, 4'd0, 11'(len)};
  endfunction

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h8000_0000;
  endfunction

  task automatic put(input logic [31:0] b, input int i, input logic [31:0] ba, input logic [31:0] w);
    mem[b + 32'(i) * 8]     = ba;
    mem[b + 32'(i) * 8 + 4] = w;
  endtask

  task automatic exp_c(input logic [31:0] ba, input logic [31:0] w);
    cmd_t c;
    c.a = ba; c.l = w[10:0]; c.last = w[15]; c.nocrc = w[16];
    exp_cmd.push_back(c);
  endtask

  task automatic exp_w(input logic [31:0] a, input logic [31:0] d);
    exp_wb.push_back({a, d});
  endtask

  // memory responder and write-back monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n && dm_req && !dm_ack) begin
      dm_ack = 1'b1;
      if (dm_we) begin
        if (exp_wb.size() == 0) begin
          chk(0, cur_req, "unexpected write", {dm_addr, dm_wdata}, 64'h0);
        end else begin
          logic [63:0] e;
          e = exp_wb.pop_front();
          chk({dm_addr, dm_wdata} == e, cur_req, "write-back", {dm_addr, dm_wdata}, e);
        end
        mem[dm_addr] = dm_wdata;
      end else begin
        dm_rdata = rd(dm_addr);
      end
    end else begin
      dm_ack = 1'b0;
    end
  end

  // transmitter model and command monitor
  always @(negedge clk) begin
    if (bc_fcs_bad) fcs_cnt++;
    fc_valid = 1'b0;
    if (done_tmr > 0) begin
      done_tmr--;
      if (done_tmr == 0) begin
        fc_valid = 1'b1;
        fc_code  = (codes.size() > 0) ? 2'(codes.pop_front()) : 2'd0;
      end
    end
    if (bp_cnt > 0) begin
      bc_ready = 1'b0;
      bp_cnt--;
    end else begin
      bc_ready = 1'b1;
    end
    if (rst_n && bc_valid && bc_ready) begin
      if (exp_cmd.size() == 0) begin
        chk(0, cur_req, "unexpected command", {bc_addr, 21'd0, bc_len}, 64'h0);
      end else begin
        cmd_t e;
        e = exp_cmd.pop_front();
        chk(bc_addr == e.a && bc_len == e.l && bc_last == e.last && bc_nocrc == e.nocrc,
            cur_req, "command", {bc_addr, 19'd0, bc_nocrc, bc_last, bc_len},
            {e.a, 19'd0, e.nocrc, e.last, e.l});
      end
      if (bc_last) done_tmr = 3;
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (cyc > 190000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk); qbase_wr = 1'b1; qbase_addr = b;
    @(negedge clk); qbase_wr = 1'b0;
  endtask

  task automatic wait_stop();
    int quiet = 0;
    int t = 0;
    while (quiet < 4 && t < 40000) begin
      @(negedge clk);
      t++;
      quiet = tx_go ? 0 : quiet + 1;
    end
    chk(!tx_go, cur_req, "engine stopped", 64'(tx_go), 64'd0);
    chk(exp_cmd.size() == 0, cur_req, "commands outstanding", 64'(exp_cmd.size()), 64'd0);
    chk(exp_wb.size() == 0, cur_req, "writes outstanding", 64'(exp_wb.size()), 64'd0);
  endtask

  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] S29 = 32'h2000_0000;
  localparam logic [31:0] S28 = 32'h1000_0000;
  localparam logic [31:0] S27 = 32'h0800_0000;

  initial begin
    logic [31:0] w, wa, wb2;
    int f0;
    rst_n = 1'b0; tx_enable = 1'b0; tx_start = 1'b0; tx_halt = 1'b0;
    qbase_wr = 1'b0; qbase_addr = '0; dm_ack = 1'b0; dm_rdata = '0;
    bc_ready = 1'b1; fc_valid = 1'b0; fc_code = 2'd0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!tx_go && !bc_valid && !dm_req, "R10", "reset outputs", {bc_valid, dm_req, tx_go}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 start while disabled does nothing
    pulse_start();
    @(negedge clk);
    chk(!tx_go, "R10", "start while disabled", 64'(tx_go), 64'd0);
    tx_enable = 1'b1;
    set_base(32'h1000);

    // R1 R2 R4: single frame then two-buffer frame with a zero-length buffer
    cur_req = "R1";
    w = ctl(60, 1, 0, 0, 0); put(32'h1000, 0, 32'hA000, w); exp_c(32'hA000, w); exp_w(32'h1004, w | OWN);
    wa = ctl(0, 0, 0, 0, 0); put(32'h1000, 1, 32'hB000, wa); exp_c(32'hB000, wa);
    wb2 = ctl(100, 1, 1, 0, 0); put(32'h1000, 2, 32'hB100, wb2); exp_c(32'hB100, wb2);
    exp_w(32'h100C, wa | OWN);
    pulse_start(); wait_stop();
    chk(mem[32'h1014] == wb2, "R4", "later buffer untouched", mem[32'h1014], wb2);

    // R3 resume at same descriptor, R5 wrap back to base
    cur_req = "R3";
    w = ctl(8, 1, 0, 0, 1); put(32'h1000, 3, 32'hC000, w); exp_c(32'hC000, w); exp_w(32'h101C, w | OWN);
    pulse_start(); wait_stop();
    cur_req = "R5";
    w = ctl(16, 1, 0, 0, 0); put(32'h1000, 0, 32'hD000, w); exp_c(32'hD000, w); exp_w(32'h1004, w | OWN);
    pulse_start(); wait_stop();

    // R8 collision replays the frame
    cur_req = "R8";
    set_base(32'h2000);
    wa = ctl(10, 0, 0, 0, 0); wb2 = ctl(20, 1, 0, 0, 0);
    put(32'h2000, 0, 32'h2A00, wa); put(32'h2000, 1, 32'h2B00, wb2);
    exp_c(32'h2A00, wa); exp_c(32'h2B00, wb2); exp_c(32'h2A00, wa); exp_c(32'h2B00, wb2);
    exp_w(32'h2004, wa | OWN);
    codes.push_back(1); codes.push_back(0);
    pulse_start(); wait_stop();

    // R9 retry limit then underrun, pointer rewinds each time
    cur_req = "R9";
    set_base(32'h3000);
    w = ctl(30, 1, 0, 0, 0); put(32'h3000, 0, 32'h3A00, w); exp_c(32'h3A00, w); exp_w(32'h3004, w | OWN | S29);
    codes.push_back(2);
    pulse_start(); wait_stop();
    w = ctl(5, 1, 0, 0, 0); put(32'h3000, 0, 32'hE000, w); exp_c(32'hE000, w); exp_w(32'h3004, w | OWN);
    wa = ctl(7, 1, 0, 0, 0); put(32'h3000, 1, 32'hE100, wa); exp_c(32'hE100, wa); exp_w(32'h300C, wa | OWN | S28);
    codes.push_back(0); codes.push_back(3);
    pulse_start(); wait_stop();
    w = ctl(6, 1, 0, 0, 0); put(32'h3000, 0, 32'hE200, w); exp_c(32'hE200, w); exp_w(32'h3004, w | OWN);
    pulse_start(); wait_stop();

    // R7 owned descriptor mid-frame
    cur_req = "R7";
    set_base(32'h4000);
    w = ctl(40, 0, 0, 0, 0); put(32'h4000, 0, 32'h4A00, w); exp_c(32'h4A00, w);
    exp_w(32'h4004, w | OWN | S28 | S27);
    f0 = fcs_cnt;
    pulse_start(); wait_stop();
    chk(fcs_cnt == f0 + 1, "R7", "fcs_bad pulses", 64'(fcs_cnt - f0), 64'd1);
    w = ctl(41, 1, 0, 0, 0); put(32'h4000, 0, 32'h4B00, w); exp_c(32'h4B00, w); exp_w(32'h4004, w | OWN);
    pulse_start(); wait_stop();

    // R11 halt finishes the current frame only
    cur_req = "R11";
    set_base(32'h5000);
    w = ctl(50, 1, 0, 0, 0); put(32'h5000, 0, 32'h5A00, w); exp_c(32'h5A00, w); exp_w(32'h5004, w | OWN);
    wa = ctl(51, 1, 0, 0, 0); put(32'h5000, 1, 32'h5B00, wa);
    pulse_start();
    while (!bc_valid) @(negedge clk);
    tx_halt = 1'b1; @(negedge clk); tx_halt = 1'b0;
    wait_stop();
    exp_c(32'h5B00, wa); exp_w(32'h500C, wa | OWN);
    pulse_start(); wait_stop();

    // R10 disable mid-frame rewinds; extra start while running is harmless
    cur_req = "R10";
    set_base(32'h6000);
    w = ctl(60, 0, 0, 0, 0); wa = ctl(61, 1, 0, 0, 0);
    put(32'h6000, 0, 32'h6A00, w); put(32'h6000, 1, 32'h6B00, wa);
    exp_c(32'h6A00, w);
    pulse_start();
    while (exp_cmd.size() != 0) @(negedge clk);
    tx_enable = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(!tx_go, "R10", "disable clears go", 64'(tx_go), 64'd0);
    tx_enable = 1'b1;
    exp_c(32'h6A00, w); exp_c(32'h6B00, wa); exp_w(32'h6004, w | OWN);
    pulse_start();
    pulse_start();
    wait_stop();

    // R13 back-pressure on the command
    cur_req = "R13";
    set_base(32'h7000);
    w = ctl(70, 1, 1, 0, 0); put(32'h7000, 0, 32'h7A00, w); exp_c(32'h7A00, w); exp_w(32'h7004, w | OWN);
    bp_cnt = 12;
    pulse_start(); wait_stop();

    // R12 exactly MAX_BUFS buffers with last: normal
    cur_req = "R12";
    set_base(32'h10000);
    for (int i = 0; i < 128; i++) begin
      w = ctl(i, i == 127, 0, 0, 0);
      put(32'h10000, i, 32'h20000 + 32'(i) * 16, w);
      exp_c(32'h20000 + 32'(i) * 16, w);
    end
    exp_w(32'h10004, ctl(0, 0, 0, 0, 0) | OWN);
    pulse_start(); wait_stop();
    // R12 MAX_BUFS buffers without last: exhaustion error
    set_base(32'h18000);
    for (int i = 0; i < 130; i++) begin
      w = ctl(i + 1, 0, 0, 0, 0);
      put(32'h18000, i, 32'h30000 + 32'(i) * 16, w);
      if (i < 128) exp_c(32'h30000 + 32'(i) * 16, w);
    end
    exp_w(32'h18004, ctl(1, 0, 0, 0, 0) | OWN | S28 | S27);
    f0 = fcs_cnt;
    pulse_start(); wait_stop();
    chk(fcs_cnt == f0 + 1, "R12", "fcs_bad pulses", 64'(fcs_cnt - f0), 64'd1);

    // R6 rollover after 1024 descriptors without wrap
    cur_req = "R6";
    set_base(32'h40000);
    for (int i = 0; i < 1024; i++) begin
      w = ctl(0, 1, 0, 0, 0);
      put(32'h40000, i, 32'h80000 + 32'(i), w);
      exp_c(32'h80000 + 32'(i), w);
      exp_w(32'h40000 + 32'(i) * 8 + 4, w | OWN);
    end
    pulse_start(); wait_stop();
    w = ctl(9, 1, 0, 0, 0); put(32'h40000, 0, 32'h9000, w); exp_c(32'h9000, w); exp_w(32'h40004, w | OWN);
    pulse_start(); wait_stop();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule